// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block is the master side of a two-wire PHY management link. Software composes one 32-bit management frame and writes it as a single word into the frame register. The block then shifts that word out on the management data line, most significant bit first, at a programmable management clock rate. When the speed register asks for it, 32 ones go out before the frame. For a read frame, the block releases the data line from the second turnaround bit onward. It samples the 16 bits that the PHY returns and places them in the low half of the frame register.

When the last frame bit has been sent, an event flag is set. Software clears it by writing a one. A mask flag decides whether the event drives the interrupt output. The speed register holds a 6-bit divisor. One management clock period is twice the divisor in system clocks, so a divisor of 5 at 25 MHz gives the 2.5 MHz limit. A divisor of zero turns the link off.

The register port is a simple single-cycle write strobe with a word address. Read data is combinational.

Top module: `mgmt_master`

## Requirements
- R1: Writing address 0 while idle with a nonzero divisor stores the word and starts a transfer that sends its 32 bits MSB first on `mdioOut`, one bit per MDC period. The frame layout is: start 31:30, opcode 29:28, PHY address 27:23, register 22:18, turnaround 17:16, data 15:0.
- R2: When bit 7 of the speed register is 0, 32 ones with `mdioOe` high precede the frame. When bit 7 is 1, the frame starts at once.
- R3: The speed register (address 1) holds the divisor in bits 6:1. MDC has a period of 2×divisor system clocks, with its high phase lasting divisor clocks.
- R4: With a divisor of 0, a frame write produces no MDC rising edge and never sets the event flag.
- R5: For a read (opcode bits 29:28 = 10), `mdioOe` is low from frame bit 16 through bit 0. The 16 bits that `mdioIn` presents on the rising MDC edges of frame bits 15..0 end up in bits 15:0 of address 0, first sampled bit in bit 15.
- R6: For a write frame (opcode 01), `mdioOe` stays high for all frame bits and address 0 still reads the written word afterwards.
- R7: The end of the last frame bit sets event bit 23 at address 2. Writing 1 to bit 23 there clears it, and writing 0 leaves it unchanged.
- R8: `irq` is high exactly when event bit 23 and mask bit 23 (address 3) are both set.
- R9: A write to address 0 during a transfer is ignored: the serial stream and the final contents of address 0 are those of the earlier frame.
- R10: After reset, all four registers read 0, and `mdc`, `mdioOe` and `irq` are low.
- R11: `mdioOut` changes only while MDC is low or on its falling edge, never during the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address: 0 frame, 1 speed, 2 event, 3 mask |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on address) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data driven to the PHY |
| mdioOe | output | 1 | Drive enable for the management data pad |
| mdioIn | input | 1 | Serial data returned by the PHY |
| irq | output | 1 | Masked completion interrupt |

## Verification
The transfer starts on the clock edge that takes the frame write. Serial bit k is then due on the k-th MDC rising edge, which comes divisor clocks after the start of its slot. The event flag appears exactly (pre+32)×2×divisor clocks after that write, where pre is 32 or 0. The bench records each rising and falling edge of MDC, so bit values, edge counts, period and high time are measured at the edges themselves rather than at guessed cycles. The returned data and the event are read only after polling shows the event set. The bench's PHY model changes `mdioIn` on MDC falling edges, so each bit is settled a full low phase before the edge that samples it.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FRAME_BITS = 32;
  localparam int PRE_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int EVT_BIT    = 23;

  localparam logic [1:0] ADDR_FRAME = 2'd0;
  localparam logic [1:0] ADDR_SPEED = 2'd1;
  localparam logic [1:0] ADDR_EVENT = 2'd2;
  localparam logic [1:0] ADDR_MASK  = 2'd3;

  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FRAME = 2'd2
  } mgmtState_e;

  typedef struct packed {
    logic load;      // capture frame into shifter
    logic shift;     // advance to next frame bit
    logic sample;    // capture mdioIn into data field
    logic done;      // last frame bit finished
    logic drvOne;    // preamble phase
    logic frameAct;  // frame phase
  } mgmtStrobe_t;
endpackage

// File: rtl/mgmt_ctrl.sv
module mgmt_ctrl
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWr,
  input  logic [1:0]       opField,
  input  logic [DIV_W-1:0] divisor,
  input  logic             preDis,
  output mgmtStrobe_t      st,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe
);
  localparam int MAXB  = (FRAME_BITS > PRE_BITS) ? FRAME_BITS : PRE_BITS;
  localparam int CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] TA2_POS    = CNT_W'(DATA_BITS);

  mgmtState_e       state;
  logic [DIV_W-1:0] phaseCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             mdcQ;
  logic             isRead;
  logic             start, phaseEnd, riseNow, slotEnd;

  assign busy     = (state != ST_IDLE);
  assign start    = dataWr && !busy && (divisor != '0);
  assign phaseEnd = busy && (phaseCnt >= divisor - 1'b1);
  assign riseNow  = phaseEnd && !mdcQ;
  assign slotEnd  = phaseEnd && mdcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      mdcQ     <= 1'b0;
      isRead   <= 1'b0;
    end else if (start) begin
      state    <= preDis ? ST_FRAME : ST_PRE;
      bitCnt   <= preDis ? FRAME_LAST : PRE_LAST;
      phaseCnt <= '0;
      mdcQ     <= 1'b0;
      isRead   <= (opField == OP_READ);
    end else if (busy) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        mdcQ     <= ~mdcQ;
        if (mdcQ) begin
          if (bitCnt != '0) begin
            bitCnt <= bitCnt - 1'b1;
          end else if (state == ST_PRE) begin
            state  <= ST_FRAME;
            bitCnt <= FRAME_LAST;
          end else begin
            state <= ST_IDLE;
          end
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st          = '0;
    st.load     = start;
    st.drvOne   = (state == ST_PRE);
    st.frameAct = (state == ST_FRAME);
    st.shift    = slotEnd && st.frameAct && (bitCnt != '0);
    st.done     = slotEnd && st.frameAct && (bitCnt == '0);
    st.sample   = riseNow && st.frameAct && isRead && (bitCnt < TA2_POS);
  end

  assign mdc    = mdcQ;
  assign mdioOe = st.drvOne || (st.frameAct && !(isRead && bitCnt <= TA2_POS));

  // R4: an idle link with zero divisor never starts
  p_off_stays_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && divisor == '0) |=> !busy);
  // R7: completion returns the controller to idle
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.done |=> !busy);
  // R3: clock only toggles while a transfer runs
  p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
endmodule

// File: rtl/mgmt_datapath.sv
module mgmt_datapath
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic             mdioIn,
  input  mgmtStrobe_t      st,
  input  logic             busy,
  output logic [31:0]      regRdata,
  output logic             mdioOut,
  output logic             irq,
  output logic [DIV_W-1:0] divisor,
  output logic             preDis
);
  logic [FRAME_BITS-1:0] frameReg;
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  eventBit;
  logic                  maskBit;
  logic                  wrFrame, wrSpeed, wrEvent, wrMask;

  assign wrFrame = regWe && (regAddr == ADDR_FRAME);
  assign wrSpeed = regWe && (regAddr == ADDR_SPEED);
  assign wrEvent = regWe && (regAddr == ADDR_EVENT);
  assign wrMask  = regWe && (regAddr == ADDR_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
    end else if (wrFrame && !busy) begin
      frameReg <= regWdata;
    end else if (st.sample) begin
      frameReg[DATA_BITS-1:0] <= {frameReg[DATA_BITS-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (st.load) begin
      shiftReg <= regWdata;
    end else if (st.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= '0;
      preDis  <= 1'b0;
      maskBit <= 1'b0;
    end else begin
      if (wrSpeed) begin
        divisor <= regWdata[DIV_W:1];
        preDis  <= regWdata[DIV_W+1];
      end
      if (wrMask) maskBit <= regWdata[EVT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventBit <= 1'b0;
    end else if (st.done) begin
      eventBit <= 1'b1;
    end else if (wrEvent && regWdata[EVT_BIT]) begin
      eventBit <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_FRAME: regRdata = frameReg;
      ADDR_SPEED: begin
        regRdata[DIV_W:1]  = divisor;
        regRdata[DIV_W+1]  = preDis;
      end
      ADDR_EVENT: regRdata[EVT_BIT] = eventBit;
      default:    regRdata[EVT_BIT] = maskBit;
    endcase
  end

  assign mdioOut = st.frameAct ? shiftReg[FRAME_BITS-1] : st.drvOne;
  assign irq     = eventBit && maskBit;

  // R7: completion sets the event flag
  p_event_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.done |=> eventBit);
  // R7: write-one clears when no completion collides
  p_event_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvent && regWdata[EVT_BIT] && !st.done) |=> !eventBit);
  // R9: frame writes during a transfer leave the register alone
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrFrame && busy && !st.sample) |=> $stable(frameReg));
endmodule

// File: rtl/mgmt_master.sv
module mgmt_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn,
  output logic        irq
);
  mgmtStrobe_t      st;
  logic             busy;
  logic [DIV_W-1:0] divisor;
  logic             preDis;
  logic             dataWr;

  assign dataWr = regWe && (regAddr == ADDR_FRAME);

  mgmt_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .dataWr(dataWr), .opField(regWdata[29:28]),
    .divisor(divisor), .preDis(preDis), .st(st), .busy(busy),
    .mdc(mdc), .mdioOe(mdioOe)
  );

  mgmt_datapath #(.DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .mdioIn(mdioIn), .st(st), .busy(busy),
    .regRdata(regRdata), .mdioOut(mdioOut), .irq(irq),
    .divisor(divisor), .preDis(preDis)
  );

  // R11: data line holds still through the high phase of MDC
  p_mdio_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));
  // R5: sampling happens only with the line released
  p_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.sample |-> !mdioOe);
endmodule

// File: tb/sim_mgmt_master.sv
module sim_mgmt_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe, irq;
  logic        mdioIn = 1'b0;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit finished = 0;
  int riseCnt = 0, r0 = 0, r1 = 0, f0 = 0;
  int phyN = 0, phyPre = 32;
  logic [15:0] phyVal = '0;
  logic [63:0] stOut, stOe;

  // fields: speed[87:80] frame[79:48] phy[47:32] expect[31:0]
  localparam logic [87:0] VEC [4] = '{
    {8'h04, 32'h5192A5C3, 16'h0000, 32'h5192A5C3},
    {8'h82, 32'h608A0000, 16'h1234, 32'h608A1234},
    {8'h06, 32'h6FFEFFFF, 16'h8001, 32'h6FFE8001},
    {8'h8A, 32'h5002FFFF, 16'hFFFF, 32'h5002FFFF}
  };

  mgmt_master u0 (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      stOut[riseCnt] = mdioOut;
      stOe[riseCnt]  = mdioOe;
    end
    if (riseCnt == 0) r0 = cyc;
    if (riseCnt == 1) r1 = cyc;
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    if (riseCnt == 1) f0 = cyc;
    phyN = phyN + 1;
    if (phyN >= phyPre + 16 && phyN <= phyPre + 31)
      mdioIn = phyVal[phyPre + 31 - phyN];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic arm(input logic [7:0] spd, input logic [15:0] pv);
    phyPre = spd[7] ? 0 : 32;
    phyVal = pv;
    phyN = 0; riseCnt = 0; mdioIn = 1'b0;
    stOut = '0; stOe = '0;
  endtask

  task automatic waitEvent(output bit seen);
    logic [31:0] v;
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      rd(2'd2, v);
      seen = v[23];
    end
  endtask

  task automatic runVec(input logic [87:0] v);
    logic [7:0]  spd = v[87:80];
    logic [31:0] fr  = v[79:48];
    logic [31:0] ex  = v[31:0];
    int div = int'(spd[6:1]);
    int pre = spd[7] ? 0 : 32;
    bit isRd = (fr[29:28] == 2'b10);
    int bad = 0;
    bit seen;
    logic [31:0] d;
    wr(2'd1, {24'd0, spd});
    arm(spd, v[47:32]);
    wr(2'd0, fr);
    waitEvent(seen);
    chk(seen, "R7 event after transfer", 32'(seen), 32'd1);
    chk(riseCnt == pre + 32, "R2 MDC rising edge count", riseCnt, pre + 32);
    chk((r1 - r0) == 2 * div, "R3 MDC period", r1 - r0, 2 * div);
    chk((f0 - r0) == div, "R3 MDC high phase", f0 - r0, div);
    for (int i = 0; i < pre + 32; i++) begin
      if (i < pre) begin
        if (!(stOut[i] && stOe[i])) bad++;
      end else begin
        int p = 31 - (i - pre);
        if (isRd && p <= 16) begin
          if (stOe[i]) bad++;
        end else if (!stOe[i] || stOut[i] !== fr[p]) bad++;
      end
    end
    chk(bad == 0, isRd ? "R5 R1 read frame stream" : "R6 R1 write frame stream",
        bad, 0);
    rd(2'd0, d);
    chk(d == ex, isRd ? "R5 read data captured" : "R6 data register kept", d, ex);
    wr(2'd2, 32'h0080_0000);
  endtask

  initial begin
    logic [31:0] d;
    bit seen;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!mdc && !mdioOe && !irq, "R10 pins after reset",
        {29'd0, mdc, mdioOe, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 0, "R10 register reset value", d, 0);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) runVec(VEC[k]);

    // R4 divisor zero
    wr(2'd1, 32'h0000_0000);
    arm(8'h00, 16'h0);
    wr(2'd0, 32'h5192A5C3);
    repeat (300) @(negedge clk);
    chk(riseCnt == 0, "R4 no MDC with divisor 0", riseCnt, 0);
    rd(2'd2, d);
    chk(d[23] == 1'b0, "R4 no event with divisor 0", d, 0);

    // R9 write during transfer ignored
    wr(2'd1, 32'h0000_0004);
    arm(8'h04, 16'hBEEF);
    wr(2'd0, 32'h5192A5C3);
    repeat (20) @(negedge clk);
    wr(2'd0, 32'h608A0000);
    waitEvent(seen);
    rd(2'd0, d);
    chk(d == 32'h5192A5C3, "R9 busy write ignored", d, 32'h5192A5C3);
    chk(stOut[32] == 1'b0 && stOut[33] == 1'b1 && riseCnt == 64,
        "R9 stream unchanged", {stOut[32], stOut[33]}, 32'd1);

    // R8 mask gating and R7 clear rules
    @(negedge clk);
    chk(!irq, "R8 irq low while masked", irq, 0);
    wr(2'd3, 32'h0080_0000);
    #1 chk(irq, "R8 irq high when unmasked", irq, 1);
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, d);
    chk(d[23], "R7 write zero keeps event", d, 32'h0080_0000);
    wr(2'd2, 32'h0080_0000);
    rd(2'd2, d);
    chk(d == 0, "R7 write one clears event", d, 0);
    #1 chk(!irq, "R8 irq low after clear", irq, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule